// File: doc/BRIEF.md
# Interval Timebase Generator

This block produces the periodic interval event that tells the statistics logic to take a snapshot of its counters and clear them. It works in one of two modes. In internal mode the block decides when an interval ends. The end comes either from a free-running timer that counts a programmable number of master clock cycles, or from a one-cycle software request. A control input chooses between the two sources. Each internal event drives the shared timebase pin high for a fixed sixteen-cycle pulse.

In external mode the shared pin is an input. A two-flop synchroniser samples it, and each rising edge it detects becomes an event. In both modes every event produces a single-cycle `tick` and sets a sticky status bit. The status bit stays set until it is cleared by writing a one.

The shared pin is split into `pin_in`, `pin_out` and an output enable `pin_oe`, so a pad cell can join them.

Top module: `tbase_gen`

## Requirements
- R1: While reset is asserted and on leaving it, `tick`, `stat` and `pin_out` are 0 and the free-running count is 0.
- R2: In internal mode with `use_sw`=0 and `period`=P>0 held constant, `tick` is high for one cycle once every P clock cycles. The first tick follows the P-th edge after the count restarts. If `period` is lowered below the current count, the timer expires on the next edge.
- R3: In internal mode with `use_sw`=0 and `period`=0, the timer is stopped and `tick` never rises.
- R4: In internal mode with `use_sw`=1, the timer is held at 0. `tick` goes high in the cycle after each edge that samples `sw_req`=1, and at no other time.
- R5: In internal mode, `pin_out` goes high together with each `tick` and stays high for exactly PULSE (default 16) cycles after the most recent event. An event during a pulse restarts the full length.
- R6: `pin_oe` is 1 in internal mode (`mode_ext`=0) and 0 in external mode. `pin_out` is 0 whenever `mode_ext`=1.
- R7: In external mode, suppose `pin_in` is sampled 0 at edge n-1 and 1 at edge n. Then `tick` is high for the one cycle after edge n+2. Falling edges and steady levels create no event.
- R8: In internal mode, activity on `pin_in` creates no event.
- R9: `stat` becomes 1 on the same edge as every `tick` and holds until an edge that samples `stat_clr`=1 with no new event. An event and a clear on the same edge leave `stat` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ext | input | 1 | 1 = external timebase on the pin, 0 = internal |
| use_sw | input | 1 | Internal source: 1 = software request, 0 = timer |
| period | input | PW | Timer period in clock cycles; 0 stops the timer |
| sw_req | input | 1 | One-cycle software expiry command |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| pin_in | input | 1 | Timebase pin input path |
| pin_out | output | 1 | Timebase pin output path |
| pin_oe | output | 1 | Timebase pin output enable |
| tick | output | 1 | Single-cycle interval event |
| stat | output | 1 | Sticky event status |

## Verification
A wrong count shows up as `tick` arriving early or late within one period, so the bench compares `tick` against an independent cycle model on every cycle. A bad pulse counter shows at `pin_out` within sixteen cycles of an event, and the retrigger case makes such an error visible. A fault in the synchroniser or edge detector shifts the external tick away from its fixed three-edge latency, or makes it fire on a falling edge, and the bench catches this at the first pin toggle. A status bit that clears or sets wrongly is exposed on the edge after the offending strobe.

// File: rtl/tbase_gen.sv
module tbase_gen #(
  parameter int PW    = 16,
  parameter int PULSE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ext,
  input  logic          use_sw,
  input  logic [PW-1:0] period,
  input  logic          sw_req,
  input  logic          stat_clr,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          tick,
  output logic          stat
);
  localparam int PCW = $clog2(PULSE + 1);
  localparam logic [PCW-1:0] PLOAD = PCW'(PULSE);

  logic [PW-1:0]  cnt;
  logic [PCW-1:0] pcnt;
  logic           s0, s1, s_prev;

  wire run_tmr = !mode_ext && !use_sw && (period != '0);
  wire tmr_hit = run_tmr && (cnt >= period - PW'(1));
  wire ev_int  = use_sw ? sw_req : tmr_hit;
  wire ev_ext  = s1 & ~s_prev;
  wire ev      = mode_ext ? ev_ext : ev_int;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   cnt <= '0;
    else if (!run_tmr || tmr_hit) cnt <= '0;
    else                          cnt <= cnt + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s0     <= 1'b0;
      s1     <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s0     <= pin_in;
      s1     <= s0;
      s_prev <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            pcnt <= '0;
    else if (mode_ext)     pcnt <= '0;
    else if (ev)           pcnt <= PLOAD;
    else if (pcnt != '0)   pcnt <= pcnt - PCW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tick <= 1'b0;
      stat <= 1'b0;
    end else begin
      tick <= ev;
      stat <= ev | (stat & ~stat_clr);
    end

  assign pin_oe  = ~mode_ext;
  assign pin_out = ~mode_ext & (pcnt != '0);
endmodule

// File: rtl/tbase_gen_chk.sv
module tbase_gen_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_ext,
  input logic          use_sw,
  input logic [PW-1:0] period,
  input logic          sw_req,
  input logic          stat_clr,
  input logic          pin_out,
  input logic          tick,
  input logic          stat
);
  a_r3_zero_period_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ext && !use_sw && period == '0) |=> !tick);

  a_r4_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ext && use_sw && !sw_req) |=> !tick);

  a_r5_pulse_starts_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_out) |-> tick);

  a_r9_set_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> stat);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !stat_clr) |=> stat);
endmodule

bind tbase_gen tbase_gen_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .use_sw(use_sw),
  .period(period), .sw_req(sw_req), .stat_clr(stat_clr),
  .pin_out(pin_out), .tick(tick), .stat(stat)
);

// File: tb/tb_tbase_gen.sv
module tb_tbase_gen;
  localparam int PW = 16;
  localparam int PULSE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_ext = 0, use_sw = 0, sw_req = 0, stat_clr = 0, pin_in = 0;
  logic [PW-1:0] period = '0;
  logic pin_out, pin_oe, tick, stat;

  int total = 0, bad = 0;
  bit done = 0, auto_chk = 0;

  always #10 clk = ~clk;

  tbase_gen #(.PW(PW), .PULSE(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .use_sw(use_sw),
    .period(period), .sw_req(sw_req), .stat_clr(stat_clr), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tick(tick), .stat(stat));

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated at each rising edge
  int  m_cnt = 0, m_pc = 0;
  bit  m_tick = 0, m_stat = 0;
  bit [3:0] hist = '0;

  always @(posedge clk) begin
    bit ev;
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_tick = 0; m_stat = 0; hist = '0;
    end else begin
      bit hit;
      hist = {hist[2:0], pin_in};
      hit = !mode_ext && !use_sw && period != 0 && m_cnt >= int'(period) - 1;
      if (mode_ext)    ev = hist[2] & ~hist[3];
      else if (use_sw) ev = sw_req;
      else             ev = hit;
      if (!mode_ext && !use_sw && period != 0 && !hit) m_cnt = m_cnt + 1;
      else m_cnt = 0;
      m_stat = ev | (m_stat & ~stat_clr);
      m_tick = ev;
      if (mode_ext) m_pc = 0;
      else if (ev)  m_pc = PULSE;
      else if (m_pc > 0) m_pc = m_pc - 1;
    end
  end

  always @(negedge clk) if (auto_chk && rst_n) begin
    check(tick, m_tick, mode_ext ? "R7" : use_sw ? "R4" : (period == 0) ? "R3" : "R2");
    check(pin_out, (m_pc != 0) && !mode_ext, mode_ext ? "R6" : "R5");
    check(pin_oe, !mode_ext, "R6");
    check(stat, m_stat, "R9");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    check(tick, 0, "R1"); check(stat, 0, "R1"); check(pin_out, 0, "R1");
    rst_n = 1;
    cyc(1);
    check(tick, 0, "R1"); check(stat, 0, "R1");
    auto_chk = 1;

    // R2: directed period 5, tick after 5th edge
    period = 5;
    begin
      int seen = 0, first = -1;
      for (int i = 1; i <= 20; i++) begin
        cyc(1);
        if (tick) begin seen++; if (first < 0) first = i; end
      end
      check(first == 5, 1, "R2");
      check(seen == 4, 1, "R2");
    end

    // R8: pin activity ignored in internal mode with timer stopped
    period = 0;
    cyc(2);
    for (int i = 0; i < 30; i++) begin
      pin_in = i[1];
      cyc(1);
      check(tick, 0, "R8");
    end
    pin_in = 0;

    // R5: retrigger stretches the pulse to 5 + 16 cycles
    use_sw = 1;
    cyc(20);
    sw_req = 1; cyc(1); sw_req = 0;
    cyc(4);
    sw_req = 1; cyc(1); sw_req = 0;
    begin
      int hi = 5;
      for (int i = 0; i < 40; i++) begin
        if (pin_out) hi++;
        cyc(1);
      end
      check(hi == 21, 1, "R5");
    end

    // R9: set wins over clear, then clear alone
    sw_req = 1; stat_clr = 1; cyc(1);
    sw_req = 0; stat_clr = 0;
    check(stat, 1, "R9");
    stat_clr = 1; cyc(1); stat_clr = 0;
    check(stat, 0, "R9");

    // R7: rising edge latency in external mode
    mode_ext = 1; use_sw = 0;
    cyc(6);
    pin_in = 1;
    begin
      int pos = -1;
      for (int i = 1; i <= 10; i++) begin
        cyc(1);
        if (tick && pos < 0) pos = i;
      end
      check(pos == 3, 1, "R7");
      pin_in = 0;
      for (int i = 0; i < 8; i++) begin
        cyc(1);
        check(tick, 0, "R7");
      end
    end

    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      mode_ext = ($urandom % 3) == 0;
      use_sw   = $urandom % 2;
      period   = (($urandom % 4) == 0) ? '0 : PW'(1 + $urandom % 40);
      for (int i = 0; i < 400; i++) begin
        sw_req   = ($urandom % 13) == 0;
        stat_clr = ($urandom % 7) == 0;
        if (($urandom % 6) == 0) pin_in = ~pin_in;
        cyc(1);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule